// File: doc/BRIEF.md
# DRAM CAS Strobe Rotate Generator

This block drives the column strobe of a fast-page or EDO DRAM burst from a programmable bit pattern instead of fixed timing counters. Software supplies a 96-bit pattern that describes the active-low CAS/DQM line over a full burst. A rotate register is loaded with it at the start of each access and shifts it out least significant bit first. In full-rate mode it moves one bit per CPU clock. In half-rate mode it moves one bit every two CPU clocks. Around the strobe the block sequences the other events of the access: a row phase, RAS assertion, the switch to column addressing, a column-advance pulse per later beat, a read-capture strobe a chosen 0 to 3 cycles after each CAS rising edge, RAS release aligned to an internal memory clock (CPU clock divided by two), and a programmable precharge wait that ends with a one-cycle done pulse.

An access is requested over a valid/ready handshake. The request fields and the pattern are sampled in the cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle. A requester that sees it low must hold `req_valid` and its fields steady until acceptance. The pattern must respect the pulse rules of the mode in use. In full-rate mode the pattern must start with at least four ones and have high and low runs of at least two bits. In half-rate mode it must start with at least two ones, and runs of one bit are allowed.

Top module: `cas_rotate_gen`

## Requirements
- R1: After reset `ras_n`, `cas_n` and `req_ready` are 1, and `col_sel`, `addr_adv`, `rd_latch` and `done` are 0.
- R2: A request is accepted on a cycle with `req_valid` and `req_ready` high. `req_ready` stays low from the next cycle until the cycle `done` is high. Fields offered while `req_ready` is low have no effect on the access in progress.
- R3: In the cycle after acceptance the row phase holds `ras_n` high and `col_sel` low. `ras_n` is low in the following cycle.
- R4: From the first cycle with `ras_n` low, `cas_n` follows the pattern bits from bit 0 upward. Each bit lasts one cycle when `req_half_rate` is 0 and two cycles when it is 1.
- R5: Each access produces exactly `req_beats` (1 to 16) falling edges of `cas_n`. `cas_n` stays high after the last rising edge.
- R6: `col_sel` rises exactly one cycle before the first `cas_n` fall and stays high until `ras_n` rises, when it returns to 0.
- R7: `addr_adv` is a one-cycle pulse in the cycle `cas_n` rises, for every rise except the last, giving `req_beats`-1 pulses.
- R8: On reads (`req_write`=0), `rd_latch` pulses `req_sample_dly` cycles after each `cas_n` rise, `req_beats` times. On writes it never pulses.
- R9: On writes `ras_n` rises 1 or 2 cycles after the last `cas_n` rise. On reads it rises 2 or 3 cycles after the last `rd_latch`. Every RAS rise falls on the same phase of the divided memory clock.
- R10: `done` is a one-cycle pulse `req_precharge`+1 cycles after `ras_n` rises, and `req_ready` is high in that cycle.
- R11: The pattern is reloaded at every acceptance, so back-to-back accesses each follow their own pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block idle, request can be taken |
| req_beats | input | 5 | Beats in the burst, 1 to 16 |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_half_rate | input | 1 | 1 rotates the pattern every two CPU clocks |
| req_sample_dly | input | 2 | Read capture delay after a CAS rise, in cycles |
| req_precharge | input | 4 | Extra cycles RAS stays high before done |
| cas_pattern | input | 96 | Full-burst strobe pattern, bit 0 first, 1 = high |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe / data mask, active low |
| col_sel | output | 1 | 0 selects the row address, 1 the column address |
| addr_adv | output | 1 | Step the column address (and write data) |
| rd_latch | output | 1 | Capture read data this cycle |
| done | output | 1 | Access and precharge finished |

## Verification
The strobe is tried with several patterns: a 2-high/2-low full-rate pattern, a 3-low/2-high full-rate pattern with a longer lead, and 1-bit-pulse half-rate patterns. Comparing `cas_n` bit by bit against each pattern separates a correct rotation order and rate from a shift in the wrong direction or at the wrong speed. Burst lengths of 1, 5, 8 and 16 check the pulse counting and where it stops. Every sample delay from 0 to 3 is used on reads, together with writes, to test the capture offset and the two RAS release rules. A request held against a busy block checks that the fields are sampled only at acceptance and that a new pattern is reloaded.

// File: rtl/cas_rot_pkg.sv
package cas_rot_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_ACTIVE,
    ST_DRAIN,
    ST_PRECH
  } seq_state_e;
endpackage

// File: rtl/cas_pattern_rotator.sv
// Holds the full-burst strobe pattern and rotates it out LSB first.
module cas_pattern_rotator #(
  parameter int PAT_W = 96
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PAT_W-1:0] pattern,
  input  logic             launch,
  input  logic             active,
  input  logic             half,
  output logic             cas_n,
  output logic             rise_now,
  output logic             fall_soon
);
  logic [PAT_W-1:0] rot_q;
  logic             wait_ph;
  logic             tick_now;
  logic             next_tick;
  logic             next_bit;

  // The launch edge always moves the pattern. After that, half rate skips every other edge.
  assign tick_now  = launch | (active & ~wait_ph);
  assign next_tick = half ? ~tick_now : 1'b1;
  assign next_bit  = tick_now ? rot_q[1] : rot_q[0];
  assign rise_now  = tick_now & ~cas_n & rot_q[0];
  assign fall_soon = (launch | active) & next_tick & ~next_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rot_q   <= '1;
      cas_n   <= 1'b1;
      wait_ph <= 1'b0;
    end else begin
      if (load) begin
        rot_q <= pattern;
        cas_n <= 1'b1;
      end else if (tick_now) begin
        rot_q <= {rot_q[0], rot_q[PAT_W-1:1]};
        cas_n <= rot_q[0];
      end
      if (launch)
        wait_ph <= half;
      else if (active)
        wait_ph <= half & ~wait_ph;
    end
  end
endmodule

// File: rtl/cas_capture_delay.sv
// Delays each CAS rise by a selectable number of cycles to form the read capture strobe.
module cas_capture_delay #(
  parameter int DLY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_now,
  input  logic             rd_en,
  input  logic [DLY_W-1:0] dly,
  output logic             rd_latch
);
  localparam int TAPS = 1 << DLY_W;

  logic [TAPS-1:0] tap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tap_q[0] <= 1'b0;
    else        tap_q[0] <= rise_now;
  end

  for (genvar k = 1; k < TAPS; k++) begin : g_tap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tap_q[k] <= 1'b0;
      else        tap_q[k] <= tap_q[k-1];
    end
  end

  assign rd_latch = rd_en & tap_q[dly];
endmodule

// File: rtl/cas_ras_sequencer.sv
// Access sequencing: row phase, beat counting, RAS release alignment, precharge.
module cas_ras_sequencer
  import cas_rot_pkg::*;
#(
  parameter int BEAT_W = 5,
  parameter int DLY_W  = 2,
  parameter int PRE_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BEAT_W-1:0] req_beats,
  input  logic              req_write,
  input  logic              req_half_rate,
  input  logic [DLY_W-1:0]  req_sample_dly,
  input  logic [PRE_W-1:0]  req_precharge,
  input  logic              rise_now,
  input  logic              fall_soon,
  output logic              load,
  output logic              launch,
  output logic              active,
  output logic              half_q,
  output logic              wr_q,
  output logic [DLY_W-1:0]  dly_q,
  output logic              ras_n,
  output logic              col_sel,
  output logic              addr_adv,
  output logic              done
);
  localparam int CNT_W = (PRE_W > DLY_W + 2) ? PRE_W : DLY_W + 2;

  seq_state_e        st_q;
  logic [BEAT_W-1:0] len_q;
  logic [BEAT_W-1:0] rises_q;
  logic [PRE_W-1:0]  pre_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              mclk_q;
  logic              last_rise;

  assign req_ready = (st_q == ST_IDLE);
  assign load      = req_ready & req_valid;
  assign launch    = (st_q == ST_ROW);
  assign active    = (st_q == ST_ACTIVE);
  assign last_rise = active & rise_now & ((rises_q + BEAT_W'(1)) == len_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      len_q    <= '0;
      rises_q  <= '0;
      pre_q    <= '0;
      cnt_q    <= '0;
      mclk_q   <= 1'b0;
      half_q   <= 1'b0;
      wr_q     <= 1'b0;
      dly_q    <= '0;
      ras_n    <= 1'b1;
      col_sel  <= 1'b0;
      addr_adv <= 1'b0;
      done     <= 1'b0;
    end else begin
      mclk_q   <= ~mclk_q;
      addr_adv <= 1'b0;
      done     <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (load) begin
            len_q   <= req_beats;
            wr_q    <= req_write;
            half_q  <= req_half_rate;
            dly_q   <= req_sample_dly;
            pre_q   <= req_precharge;
            rises_q <= '0;
            st_q    <= ST_ROW;
          end
        end
        ST_ROW: begin
          ras_n <= 1'b0;
          st_q  <= ST_ACTIVE;
        end
        ST_ACTIVE: begin
          if (fall_soon) col_sel <= 1'b1;
          if (last_rise) begin
            st_q  <= ST_DRAIN;
            cnt_q <= wr_q ? CNT_W'(1) : (CNT_W'(dly_q) + CNT_W'(2));
          end else if (rise_now) begin
            rises_q  <= rises_q + BEAT_W'(1);
            addr_adv <= 1'b1;
          end
        end
        ST_DRAIN: begin
          // Release only on an edge where the divided memory clock goes high.
          if ((cnt_q <= CNT_W'(1)) && !mclk_q) begin
            ras_n   <= 1'b1;
            col_sel <= 1'b0;
            cnt_q   <= CNT_W'(pre_q);
            st_q    <= ST_PRECH;
          end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        ST_PRECH: begin
          if (cnt_q == '0) begin
            done <= 1'b1;
            st_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cas_rotate_gen.sv
module cas_rotate_gen #(
  parameter int MAX_BEATS = 16,
  parameter int PAT_WORDS = 3,
  parameter int WORD_W    = 32,
  parameter int DLY_W     = 2,
  parameter int PRE_W     = 4,
  localparam int PAT_W    = PAT_WORDS * WORD_W,
  localparam int BEAT_W   = $clog2(MAX_BEATS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BEAT_W-1:0] req_beats,
  input  logic              req_write,
  input  logic              req_half_rate,
  input  logic [DLY_W-1:0]  req_sample_dly,
  input  logic [PRE_W-1:0]  req_precharge,
  input  logic [PAT_W-1:0]  cas_pattern,
  output logic              ras_n,
  output logic              cas_n,
  output logic              col_sel,
  output logic              addr_adv,
  output logic              rd_latch,
  output logic              done
);
  logic             load, launch, active, half_q, wr_q;
  logic             rise_now, fall_soon;
  logic [DLY_W-1:0] dly_q;

  cas_ras_sequencer #(
    .BEAT_W(BEAT_W), .DLY_W(DLY_W), .PRE_W(PRE_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_beats(req_beats), .req_write(req_write),
    .req_half_rate(req_half_rate), .req_sample_dly(req_sample_dly),
    .req_precharge(req_precharge),
    .rise_now(rise_now), .fall_soon(fall_soon),
    .load(load), .launch(launch), .active(active),
    .half_q(half_q), .wr_q(wr_q), .dly_q(dly_q),
    .ras_n(ras_n), .col_sel(col_sel), .addr_adv(addr_adv), .done(done)
  );

  cas_pattern_rotator #(.PAT_W(PAT_W)) u_rot (
    .clk(clk), .rst_n(rst_n),
    .load(load), .pattern(cas_pattern),
    .launch(launch), .active(active), .half(half_q),
    .cas_n(cas_n), .rise_now(rise_now), .fall_soon(fall_soon)
  );

  cas_capture_delay #(.DLY_W(DLY_W)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .rise_now(rise_now), .rd_en(~wr_q), .dly(dly_q),
    .rd_latch(rd_latch)
  );
endmodule

// File: rtl/cas_rotate_chk.sv
module cas_rotate_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic ras_n,
  input logic cas_n,
  input logic col_sel,
  input logic addr_adv,
  input logic rd_latch,
  input logic done,
  input logic wr_q
);
  // R10: done lasts a single cycle
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5: the column strobe only goes low inside an open row
  a_r5_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);
  // R2: ready only while no row is open
  a_r2_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> ras_n);
  // R6: column address selected one cycle before any CAS fall
  a_r6_col_before_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> $past(col_sel));
  // R7: address advance coincides with a CAS rise
  a_r7_adv_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    addr_adv |-> $rose(cas_n));
  // R8: no capture strobe on writes
  a_r8_no_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
    rd_latch |-> !wr_q);
  // R9: RAS releases with CAS high and the row address selected again
  a_r9_ras_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (cas_n && !col_sel));
endmodule

bind cas_rotate_gen cas_rotate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .ras_n(ras_n),
  .cas_n(cas_n), .col_sel(col_sel), .addr_adv(addr_adv),
  .rd_latch(rd_latch), .done(done), .wr_q(wr_q)
);

// File: tb/cas_rotate_gen_bench.sv
`timescale 1ns/1ps
module cas_rotate_gen_bench;
  localparam int PW = 96;
  localparam int NREC = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [4:0] req_beats = '0;
  logic req_write = 1'b0;
  logic req_half_rate = 1'b0;
  logic [1:0] req_sample_dly = '0;
  logic [3:0] req_precharge = '0;
  logic [PW-1:0] cas_pattern = '1;
  logic ras_n, cas_n, col_sel, addr_adv, rd_latch, done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int ras_par = -1;
  bit finished = 0;

  bit r_cas[NREC], r_ras[NREC], r_col[NREC], r_adv[NREC], r_lat[NREC], r_done[NREC], r_rdy[NREC];
  int n_rec;
  int base;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cas_rotate_gen u_cas_rotate_gen (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_beats(req_beats), .req_write(req_write), .req_half_rate(req_half_rate),
    .req_sample_dly(req_sample_dly), .req_precharge(req_precharge),
    .cas_pattern(cas_pattern), .ras_n(ras_n), .cas_n(cas_n), .col_sel(col_sel),
    .addr_adv(addr_adv), .rd_latch(rd_latch), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] mk_pat(input int lead, input int lo, input int hi);
    logic [PW-1:0] p = '1;
    int pos = lead;
    for (int b = 0; b < 16; b++) begin
      for (int k = 0; k < lo; k++) begin if (pos < PW) p[pos] = 1'b0; pos++; end
      pos += hi;
    end
    return p;
  endfunction

  task automatic sample(input int i);
    r_cas[i] = cas_n; r_ras[i] = ras_n; r_col[i] = col_sel; r_adv[i] = addr_adv;
    r_lat[i] = rd_latch; r_done[i] = done; r_rdy[i] = req_ready;
  endtask

  task automatic run_access(input logic [PW-1:0] pat, input int len, input bit wr,
                            input bit half, input int dly, input int pc);
    int i, f, h, d, lr, lr_exp, bad, falls, advs, lats, rises, ilow, lt;
    bit prev, e;
    int rep;
    @(negedge clk);
    cas_pattern = pat; req_beats = 5'(len); req_write = wr; req_half_rate = half;
    req_sample_dly = 2'(dly); req_precharge = 4'(pc); req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    base = cyc;
    i = 0;
    sample(0);
    while (!r_done[i] && i < NREC - 1) begin
      @(negedge clk);
      i++;
      sample(i);
    end
    n_rec = i + 1;
    d = i;
    // R2 / R3: row phase then RAS
    chk(r_rdy[0] == 0 && r_ras[0] == 1 && r_col[0] == 0, "R3", "row phase ras/col/ready", int'(r_ras[0]), 1);
    chk(r_ras[1] == 0, "R3", "ras low after row phase", int'(r_ras[1]), 0);
    ilow = 0;
    for (int k = 1; k < d; k++) if (r_rdy[k]) ilow++;
    chk(ilow == 0, "R2", "ready high while busy", ilow, 0);
    // R4: pattern order and rate
    rep = half ? 2 : 1;
    i = 1; prev = 1; rises = 0; bad = 0; lr_exp = 0;
    for (int bi = 0; bi < PW && rises < len; bi++)
      for (int k = 0; k < rep && rises < len; k++) begin
        e = pat[bi];
        if (r_cas[i] !== e) bad++;
        if (!prev && e) begin rises++; lr_exp = i; end
        prev = e; i++;
      end
    chk(bad == 0, "R4", "cas_n sequence mismatches", bad, 0);
    // R5: pulse count and idle high afterwards
    falls = 0; lr = 0; f = 0;
    for (int k = 1; k < n_rec; k++) begin
      if (!r_cas[k] && r_cas[k-1]) begin falls++; if (f == 0) f = k; end
      if (r_cas[k] && !r_cas[k-1]) lr = k;
    end
    chk(falls == len, "R5", "cas_n falling edges", falls, len);
    bad = 0;
    for (int k = lr_exp + 1; k < n_rec; k++) if (!r_cas[k]) bad++;
    chk(bad == 0 && lr == lr_exp, "R5", "last rise index", lr, lr_exp);
    // R9: RAS release
    h = 0;
    for (int k = 2; k < n_rec; k++) if (h == 0 && r_ras[k]) h = k;
    // R6: column select window
    bad = 0;
    for (int k = 1; k < n_rec; k++) begin
      e = (k >= f - 1) && (k < h);
      if (r_col[k] !== e) bad++;
    end
    chk(bad == 0, "R6", "col_sel window mismatches", bad, 0);
    // R7: advance pulses
    advs = 0; bad = 0;
    for (int k = 1; k < n_rec; k++) if (r_adv[k]) begin
      advs++;
      if (!(r_cas[k] && !r_cas[k-1] && k != lr)) bad++;
    end
    chk(advs == len - 1 && bad == 0, "R7", "addr_adv pulses", advs, len - 1);
    // R8: read capture
    lats = 0; bad = 0; lt = 0;
    for (int k = 1; k < n_rec; k++) begin
      if (r_lat[k]) begin lats++; lt = k; end
      if (!wr && r_cas[k] && !r_cas[k-1] && (k + dly >= n_rec || !r_lat[k + dly])) bad++;
    end
    chk(lats == (wr ? 0 : len) && bad == 0, "R8", "rd_latch pulses", lats, wr ? 0 : len);
    if (wr) chk(h - lr == 1 || h - lr == 2, "R9", "write ras release after last rise", h - lr, 1);
    else    chk(h - lt == 2 || h - lt == 3, "R9", "read ras release after last latch", h - lt, 2);
    if (ras_par < 0) ras_par = (base + h) % 2;
    chk((base + h) % 2 == ras_par, "R9", "ras release memory clock phase", (base + h) % 2, ras_par);
    // R10: precharge and done
    chk(d == h + pc + 1 && r_rdy[d], "R10", "done offset from ras rise", d - h, pc + 1);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && req_ready && !col_sel && !addr_adv && !rd_latch && !done,
        "R1", "reset outputs", {ras_n, cas_n, req_ready, col_sel, addr_adv, rd_latch, done}, 7'b1110000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ras_n && cas_n && req_ready && !done, "R1", "idle after reset", int'(ras_n), 1);
  endtask

  task automatic t_full_write;  run_access(mk_pat(4, 2, 2), 8, 1, 0, 0, 2); endtask
  task automatic t_full_read0;  run_access(mk_pat(4, 2, 2), 8, 0, 0, 0, 0); endtask
  task automatic t_full_read3;  run_access(mk_pat(5, 3, 2), 5, 0, 0, 3, 5); endtask
  task automatic t_half_read;   run_access(mk_pat(2, 1, 1), 16, 0, 1, 1, 1); endtask
  task automatic t_half_write;  run_access(mk_pat(2, 1, 2), 16, 1, 1, 0, 3); endtask
  task automatic t_single_beat; run_access(mk_pat(4, 2, 3), 1, 0, 0, 2, 0); endtask

  // R2 / R11: request held against a busy block, new fields and pattern apply only after done
  task automatic t_backpressure;
    int falls_a, falls_b, waitc;
    bit pc_prev, seen_done;
    @(negedge clk);
    cas_pattern = mk_pat(4, 2, 2); req_beats = 5'd2; req_write = 1'b1;
    req_half_rate = 1'b0; req_sample_dly = 2'd0; req_precharge = 4'd1; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    cas_pattern = mk_pat(6, 3, 3); req_beats = 5'd3; req_half_rate = 1'b1;
    falls_a = 0; waitc = 0; pc_prev = cas_n; seen_done = 0;
    while (!req_ready && waitc < 300) begin
      @(negedge clk);
      if (!cas_n && pc_prev) falls_a++;
      pc_prev = cas_n; waitc++;
      if (done) seen_done = 1;
    end
    chk(seen_done && req_ready, "R2", "ready returns with done", int'(seen_done), 1);
    chk(falls_a == 2, "R2", "beats of first access under held request", falls_a, 2);
    @(negedge clk);
    req_valid = 1'b0;
    falls_b = 0; waitc = 0; pc_prev = cas_n;
    while (!done && waitc < 300) begin
      @(negedge clk);
      if (!cas_n && pc_prev) falls_b++;
      pc_prev = cas_n; waitc++;
    end
    chk(falls_b == 3, "R11", "beats of queued access", falls_b, 3);
    // The queued half-rate pattern begins with 6 ones held 2 cycles each, so the first fall is late.
    run_access(mk_pat(6, 3, 3), 3, 0, 1, 2, 0);
  endtask

  initial begin
    t_reset();
    t_full_write();
    t_full_read0();
    t_full_read3();
    t_half_read();
    t_half_write();
    t_single_beat();
    t_backpressure();
    repeat (4) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule